// File: doc/BRIEF.md
# Multiplexed I/Q Interpolate-by-Four FIR

This block is a lowpass FIR interpolator for a pair of one-bit chip streams, one for the in-phase (I) and one for the quadrature (Q) channel. Each accepted input pair produces four output samples per channel, so eight results leave the block per input. Because the two channels use the same tap set, a single datapath serves both by time multiplexing. Each phase is computed for I and then for Q.

A chip is treated as +1 or -1, so a tap is added or subtracted and no multiplier is needed. The zero-stuffed positions of the upsampled stream are not computed. The sequencer points the coefficient read at a zero-filled upper half of the tap memory instead. Each output sums the contributions of two read ports through two accumulators. Each accumulator has a pipeline register, and a final adder that cannot overflow joins their results. A host loads the eight taps while the block is in program mode.

Top module: `iq_interp_fir`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and every tap reads as zero, so outputs computed before any programming are zero.
- R2: Each accepted input (in_valid high while in_ready is high) yields exactly eight results. The order is phase 0 to phase 3, and within each phase I comes first (out_q = 0) and Q follows (out_q = 1). Two results never fall in adjacent cycles.
- R3: A chip value of 1 adds its tap and a chip value of 0 subtracts it (two's complement).
- R4: Phase p (0..3) of a channel sums two terms. The first is tap h[p] applied to that channel's newest chip. The second is tap h[p+4] applied to the chip accepted before it.
- R5: An empty delay-line position contributes zero. Positions are empty after reset, and they are empty after the line is cleared. Such a position is served from the zero half of the tap memory.
- R6: in_ready is low while the sequencer is working on an input and while program mode is on. An in_valid pulse during that time is dropped and produces no results.
- R7: A tap write (coef_we, address coef_addr 0..7 = tap index k, value coef_wdata) takes effect only when prog_en is high and the block is idle. A write while prog_en is low is ignored.
- R8: Leaving program mode (prog_en falling) empties both channels' delay lines.
- R9: The final sum covers the full range of two 12-bit taps, for example +4096 when both taps are -2048 and both chips are 0, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Program mode: host owns the tap memory, inputs are refused |
| coef_we | input | 1 | Tap write strobe |
| coef_addr | input | 3 | Tap index k written (0..7) |
| coef_wdata | input | 12 | Signed tap value |
| in_valid | input | 1 | Input chip pair present |
| in_ready | output | 1 | Block can accept an input pair this cycle |
| in_chip_i | input | 1 | I chip (1 = +1, 0 = -1) |
| in_chip_q | input | 1 | Q chip (1 = +1, 0 = -1) |
| out_valid | output | 1 | Result present on out_data |
| out_q | output | 1 | Channel of the result: 0 = I, 1 = Q |
| out_data | output | 15 | Signed filter output |

## Verification
Several rules are checked by the assertions on every cycle. in_ready must stay low in program mode and right after an acceptance. Results must never arrive back to back, must alternate between I and Q, and must never outnumber eight per accepted input. The numerical behaviour needs the bench's scenarios: the tap and sign mapping of each phase, the empty delay positions after reset and after program mode, dropped writes and inputs, and the extreme-value sums. There, a scoreboard model predicts every result and compares it with the design.

// File: rtl/iq_fir_pkg.sv
// Shared defaults and types for the multiplexed I/Q interpolating FIR.
// Assumes the filter spans two input samples: TAPS = 2 * UPS.
package iq_fir_pkg;
    localparam int DEF_CW  = 12;  // tap width
    localparam int DEF_UPS = 4;   // interpolation factor

    typedef enum logic {
        CH_I = 1'b0,
        CH_Q = 1'b1
    } chan_t;
endpackage

// File: rtl/fir_coef_ram.sv
// Tap memory: one write port sharing port A's address and two registered
// read ports. The lower half holds the taps. The upper half is never
// written and stays zero, and it serves stuffed-zero positions.
// Assumes the caller never writes the upper half.
module fir_coef_ram #(
    parameter int CW  = 12,
    parameter int RAW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RAW-1:0] addr_a,
    input  logic [CW-1:0] wdata,
    input  logic [RAW-1:0] addr_b,
    output logic [CW-1:0] rdata_a,
    output logic [CW-1:0] rdata_b
);
    localparam int DEPTH = 1 << RAW;

    logic [CW-1:0] mem [DEPTH];

    // Storage: cleared by reset, written by the host through port A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr_a] <= wdata;
        end
    end

    // Synchronous reads on both ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_a <= '0;
            rdata_b <= '0;
        end else begin
            rdata_a <= mem[addr_a];
            rdata_b <= mem[addr_b];
        end
    end
endmodule

// File: rtl/fir_seq.sv
// Sequencer: holds the two-deep chip delay lines per channel and walks
// phases 0..UPS-1, each phase for I and then for Q, issuing one tap pair
// per cycle. Port A reads tap k = step and port B reads tap k = step+UPS.
// A tap is real only when step equals the phase and its delay position is
// filled; otherwise the zero half is addressed.
module fir_seq
    import iq_fir_pkg::*;
#(
    parameter int UPS = 4,
    localparam int UW  = $clog2(UPS),
    localparam int RAW = UW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_en,
    input  logic           in_valid,
    input  logic           chip_i,
    input  logic           chip_q,
    output logic           in_ready,
    output logic           busy,
    output logic [RAW-1:0] addr_a,
    output logic [RAW-1:0] addr_b,
    output logic           neg_a,
    output logic           neg_b,
    output logic           iss_vld,
    output logic           iss_first,
    output logic           iss_last,
    output logic           iss_chan
);
    logic [UW-1:0] phase, step;
    chan_t         chan;
    logic          prog_d;
    logic [1:0]    dl_i, dl_q, dl_v;   // index 0 is the newest chip
    logic          accept, hit, chip_new, chip_old;

    assign in_ready = !busy && !prog_en && !prog_d;
    assign accept   = in_valid && in_ready;

    // State: delay lines, clear on leaving program mode, phase walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            phase  <= '0;
            step   <= '0;
            chan   <= CH_I;
            prog_d <= 1'b0;
            dl_i   <= '0;
            dl_q   <= '0;
            dl_v   <= '0;
        end else begin
            prog_d <= prog_en;
            if (accept) begin
                dl_i  <= {dl_i[0], chip_i};
                dl_q  <= {dl_q[0], chip_q};
                dl_v  <= {dl_v[0], 1'b1};
                busy  <= 1'b1;
                phase <= '0;
                step  <= '0;
                chan  <= CH_I;
            end else begin
                if (prog_d && !prog_en) dl_v <= '0;
                if (busy) begin
                    if (step == UW'(UPS - 1)) begin
                        step <= '0;
                        chan <= (chan == CH_I) ? CH_Q : CH_I;
                        if (chan == CH_Q) begin
                            if (phase == UW'(UPS - 1)) busy <= 1'b0;
                            else phase <= phase + 1'b1;
                        end
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            end
        end
    end

    // Read request for the current step.
    always_comb begin
        hit       = busy && (step == phase);
        chip_new  = (chan == CH_Q) ? dl_q[0] : dl_i[0];
        chip_old  = (chan == CH_Q) ? dl_q[1] : dl_i[1];
        addr_a    = {~(hit && dl_v[0]), 1'b0, step};
        addr_b    = {~(hit && dl_v[1]), 1'b1, step};
        neg_a     = !chip_new;
        neg_b     = !chip_old;
        iss_vld   = busy;
        iss_first = (step == '0);
        iss_last  = (step == UW'(UPS - 1));
        iss_chan  = chan;
    end
endmodule

// File: rtl/fir_acc.sv
// Operand accumulator: adds or subtracts one tap per valid cycle, restarts
// on 'first', and loads its pipeline register with the total on 'last'.
// Assumes OW is wide enough for the operands summed in one pass.
module fir_acc #(
    parameter int IW = 12,
    parameter int OW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_vld,
    input  logic                 first,
    input  logic                 last,
    input  logic                 neg,
    input  logic [IW-1:0]        operand,
    output logic signed [OW-1:0] psum
);
    logic signed [OW-1:0] ext, term, acc, acc_next;

    // Signed extension, conditional negation and running sum.
    always_comb begin
        ext      = {{(OW-IW){operand[IW-1]}}, operand};
        term     = neg ? -ext : ext;
        acc_next = (first ? '0 : acc) + term;
    end

    // Running sum and the pipeline register behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            psum <= '0;
        end else if (op_vld) begin
            acc <= acc_next;
            if (last) psum <= acc_next;
        end
    end
endmodule

// File: rtl/iq_interp_fir.sv
// Top: interpolate-by-UPS lowpass FIR shared by I and Q. The sequencer
// issues tap reads, the tap memory returns them one cycle later, two
// accumulators sum them, and a final adder joins the partial sums.
// Assumes the host changes taps only while prog_en is high and idle.
module iq_interp_fir
    import iq_fir_pkg::*;
#(
    parameter int CW  = DEF_CW,
    parameter int UPS = DEF_UPS,
    localparam int UW  = $clog2(UPS),
    localparam int RAW = UW + 2,
    localparam int AW  = UW + 1,
    localparam int PW  = CW + UW,
    localparam int OW  = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          coef_we,
    input  logic [AW-1:0] coef_addr,
    input  logic [CW-1:0] coef_wdata,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_chip_i,
    input  logic          in_chip_q,
    output logic          out_valid,
    output logic          out_q,
    output logic [OW-1:0] out_data
);
    logic           busy, host_sel, ram_we;
    logic [RAW-1:0] seq_addr_a, seq_addr_b, ram_addr_a;
    logic           iss_vld, iss_first, iss_last, iss_chan;
    logic [1:0]     iss_neg;
    logic [CW-1:0]  rd [2];
    logic           s1_vld, s1_first, s1_last, s1_chan;
    logic [1:0]     s1_neg;
    logic signed [PW-1:0] psum [2];
    logic           p_vld, p_chan;

    fir_seq #(.UPS(UPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
        .in_valid(in_valid), .chip_i(in_chip_i), .chip_q(in_chip_q),
        .in_ready(in_ready), .busy(busy),
        .addr_a(seq_addr_a), .addr_b(seq_addr_b),
        .neg_a(iss_neg[0]), .neg_b(iss_neg[1]),
        .iss_vld(iss_vld), .iss_first(iss_first),
        .iss_last(iss_last), .iss_chan(iss_chan)
    );

    // Host owns port A only in program mode with no pass in flight.
    assign host_sel   = prog_en && !busy;
    assign ram_we     = host_sel && coef_we;
    assign ram_addr_a = host_sel ? {1'b0, coef_addr} : seq_addr_a;

    fir_coef_ram #(.CW(CW), .RAW(RAW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we),
        .addr_a(ram_addr_a), .wdata(coef_wdata), .addr_b(seq_addr_b),
        .rdata_a(rd[0]), .rdata_b(rd[1])
    );

    // Stage 1: control aligned with the registered memory output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_chan  <= 1'b0;
            s1_neg   <= '0;
        end else begin
            s1_vld   <= iss_vld;
            s1_first <= iss_first;
            s1_last  <= iss_last;
            s1_chan  <= iss_chan;
            s1_neg   <= iss_neg;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_acc
        fir_acc #(.IW(CW), .OW(PW)) u_acc (
            .clk(clk), .rst_n(rst_n), .op_vld(s1_vld),
            .first(s1_first), .last(s1_last), .neg(s1_neg[g]),
            .operand(rd[g]), .psum(psum[g])
        );
    end

    // Stage 2: marks when the accumulator pipeline registers hold a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_vld  <= 1'b0;
            p_chan <= 1'b0;
        end else begin
            p_vld  <= s1_vld && s1_last;
            if (s1_vld && s1_last) p_chan <= s1_chan;
        end
    end

    // Stage 3: final sum, one bit wider than the partial sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_q     <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= p_vld;
            if (p_vld) begin
                out_q    <= p_chan;
                out_data <= {psum[0][PW-1], psum[0]} + {psum[1][PW-1], psum[1]};
            end
        end
    end
endmodule

// File: rtl/iq_interp_fir_chk.sv
// Protocol checker for iq_interp_fir, attached by bind. Tracks the number
// of results still owed and the channel of the previous result.
module iq_interp_fir_chk #(
    parameter int UPS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic prog_en,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_q
);
    logic [15:0] pending;
    logic        seen, last_q;

    // Bookkeeping of owed results and the previous channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            seen    <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            pending <= pending + ((in_valid && in_ready) ? 16'(2 * UPS) : 16'd0)
                               - (out_valid ? 16'd1 : 16'd0);
            if (out_valid) begin
                seen   <= 1'b1;
                last_q <= out_q;
            end
        end
    end

    // R6
    prog_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !in_ready);

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    out_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2
    iq_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> (out_q != last_q));

    // R2
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pending != 16'd0));
endmodule

bind iq_interp_fir iq_interp_fir_chk #(.UPS(UPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_q(out_q)
);

// File: tb/iq_interp_fir_tb.sv
`timescale 1ns/1ps
module iq_interp_fir_tb;
    localparam int CW = 12;
    localparam int OW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_en = 1'b0, coef_we = 1'b0;
    logic [2:0]    coef_addr = '0;
    logic [CW-1:0] coef_wdata = '0;
    logic          in_valid = 1'b0, in_chip_i = 1'b0, in_chip_q = 1'b0;
    logic          in_ready, out_valid, out_q;
    logic [OW-1:0] out_data;

    iq_interp_fir u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_chip_i(in_chip_i), .in_chip_q(in_chip_q),
        .out_valid(out_valid), .out_q(out_q), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    typedef struct { bit q; int val; string req; } exp_t;
    exp_t sbq[$];
    int   total = 0, bad = 0;
    int   coef[8];
    bit   mi[2], mq[2], mv[2];

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int term(bit chip, int h);
        return chip ? h : -h;
    endfunction

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
    endtask

    // Driver: model update, eight expected results, then one strobe.
    task automatic send(bit ci, bit cq, string req);
        wait_idle();
        mi[1] = mi[0]; mi[0] = ci;
        mq[1] = mq[0]; mq[0] = cq;
        mv[1] = mv[0]; mv[0] = 1'b1;
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 2; c++) begin
                exp_t e;
                bit n0, n1;
                n0 = c ? mq[0] : mi[0];
                n1 = c ? mq[1] : mi[1];
                e.q = bit'(c);
                e.val = (mv[0] ? term(n0, coef[p]) : 0)
                      + (mv[1] ? term(n1, coef[p + 4]) : 0);
                e.req = req;
                sbq.push_back(e);
            end
        end
        in_valid = 1'b1; in_chip_i = ci; in_chip_q = cq;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic write_coef(int k, int v, bit take);
        coef_we = 1'b1; coef_addr = 3'(k); coef_wdata = CW'(v);
        @(negedge clk);
        coef_we = 1'b0;
        if (take) coef[k] = v;
    endtask

    task automatic enter_prog();
        wait_idle();
        prog_en = 1'b1;
        @(negedge clk);
    endtask

    // R8: leaving program mode empties the model delay lines.
    task automatic leave_prog();
        prog_en = 1'b0;
        mv[0] = 1'b0; mv[1] = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        int n = 0;
        while (sbq.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R2 unexpected result", int'($signed(out_data)), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(out_q == e.q, {e.req, " R2 channel"}, int'(out_q), int'(e.q));
                check(int'($signed(out_data)) == e.val, {e.req, " value"},
                      int'($signed(out_data)), e.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) coef[k] = 0;
        mi = '{0, 0}; mq = '{0, 0}; mv = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        send(1, 0, "R1 zero taps");
        drain();

        // R7: program taps in program mode
        enter_prog();
        // R6: input refused in program mode
        in_valid = 1'b1; in_chip_i = 1'b1; in_chip_q = 1'b1;
        #0.1;
        check(in_ready == 1'b0, "R6 ready in program mode", int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        write_coef(0, 100, 1);  write_coef(1, -200, 1);
        write_coef(2, 300, 1);  write_coef(3, -400, 1);
        write_coef(4, 2047, 1); write_coef(5, -2048, 1);
        write_coef(6, 5, 1);    write_coef(7, -7, 1);
        leave_prog();

        // R5: first input after clear uses only the newest taps
        send(1, 0, "R5 empty old slot");
        // R6: pulse during a busy pass is dropped
        in_valid = 1'b1; in_chip_i = 1'b0; in_chip_q = 1'b0;
        #0.1;
        check(in_ready == 1'b0, "R6 ready while busy", int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        // R3 / R4: sign mapping and phase-to-tap selection
        send(0, 1, "R3 R4 pattern a");
        send(1, 1, "R3 R4 pattern b");
        send(0, 0, "R3 R4 pattern c");
        send(1, 0, "R3 R4 pattern d");
        drain();

        // R7: write outside program mode is ignored
        wait_idle();
        write_coef(0, 999, 0);
        write_coef(5, 1, 0);
        send(1, 1, "R7 ignored write");
        drain();

        // R8: leaving program mode clears history
        enter_prog();
        leave_prog();
        send(0, 1, "R8 cleared line");
        drain();

        // R9: extreme taps
        enter_prog();
        for (int k = 0; k < 8; k++) write_coef(k, -2048, 1);
        leave_prog();
        send(0, 0, "R9 extreme a");
        send(0, 0, "R9 extreme b");
        send(1, 1, "R9 extreme c");
        drain();

        check(sbq.size() == 0, "R2 all results seen", sbq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule